// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block derives the serial clock of a two-wire bus controller from a fast input clock. A programmable prescaler divides the input clock by (prescale + 1) and emits one module tick per division. Two phase counters then hold the serial clock low for (low count + d) ticks and release it high for (high count + d) ticks. The term d is a fixed internal overhead that depends on the prescale setting: 7 for a prescale of 0, 6 for a prescale of 1, and 5 for any larger prescale. A build parameter can instead pin d to a single constant.

The controller holds the block disabled while software loads the three 16-bit settings. Once enabled, the block samples the settings at the start of every serial clock period, so a write in the middle of a period takes effect only when the next period begins. A high count of zero suppresses the serial clock: the line stays released and no ticks appear. Clock stretching, START/STOP framing and data shifting belong to other blocks.

Top module: `scl_clock_divider`

## Requirements
- R1: While reset is asserted or enable is low, scl_o is 1 (released) and mod_tick_o is 0.
- R2: While the clock is running, mod_tick_o pulses for one cycle every (prescale + 1) input clock cycles.
- R3: Each serial clock period begins with scl_o at 0 for (prescale + 1) × (low count + d) input clock cycles, counted from the first clock edge after enable is sampled high.
- R4: After the low phase, scl_o is 1 for (prescale + 1) × (high count + d) input clock cycles, and then the next period begins with a low phase.
- R5: d is 7 when prescale is 0, 6 when prescale is 1, and 5 when prescale is 2 or more. A low count of 0 still gives a low phase of d ticks.
- R6: When the sampled high count is 0, scl_o stays at 1 and mod_tick_o stays at 0 for as long as the high count remains 0.
- R7: The block samples prescale, low count and high count only when it starts from idle and at the end of each period. Changes made during a period do not alter that period.
- R8: Deasserting enable in the middle of a period releases scl_o and stops the ticks at the next clock edge. A later enable starts a fresh period with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the divider when high; clears it when low |
| prescale_i | input | CNT_W | Prescaler setting; the module clock is the input clock divided by (value + 1) |
| low_cnt_i | input | CNT_W | Low-phase count, in module ticks, before the overhead is added |
| high_cnt_i | input | CNT_W | High-phase count, in module ticks, before the overhead is added; 0 stops the clock |
| scl_o | output | 1 | Serial clock drive level; 1 means released |
| mod_tick_o | output | 1 | One-cycle pulse per module clock tick |

## Verification
The hardest case to reach is a settings change that lands inside a running period. To be correct, the change must leave the current low and high phases untouched and must then reshape every later phase, including a switch to a zero high count. The stimulus writes new settings a few cycles into the first low phase, while the counters are mid-count. A scoreboard then compares the measured length of every low run and high run against lengths computed from the old settings for the first period and from the new settings after it. A second hard case is a disable that arrives partway through a low phase, followed at once by a new enable. The bench checks that the line is released before re-enabling and that the next low run is full length.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   // Width of the phase overhead term; values up to 7 fit.
   localparam int unsigned OVH_W = 3;

   // Overhead for each prescale class.
   localparam logic [OVH_W-1:0] OVH_DIV1  = 3'd7;
   localparam logic [OVH_W-1:0] OVH_DIV2  = 3'd6;
   localparam logic [OVH_W-1:0] OVH_DIVN  = 3'd5;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;

endpackage

// File: rtl/scl_div_overhead.sv
module scl_div_overhead
   import scl_div_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned FIXED_OVH = 0
) (
   input  logic [CNT_W-1:0] prescale_i,
   output logic [OVH_W-1:0] ovh_o
);

   generate
      if (FIXED_OVH > 7) begin : g_bad_ovh
         $error("scl_div_overhead: FIXED_OVH must be 0..7");
      end

      if (FIXED_OVH == 0) begin : g_table
         // Overhead shrinks as the prescaler grows.
         always_comb begin
            if (prescale_i == '0)
               ovh_o = OVH_DIV1;
            else if (prescale_i == CNT_W'(1))
               ovh_o = OVH_DIV2;
            else
               ovh_o = OVH_DIVN;
         end
      end else begin : g_fixed
         assign ovh_o = OVH_W'(FIXED_OVH);
      end
   endgenerate

endmodule

// File: rtl/scl_div_prescaler.sv
module scl_div_prescaler #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             tick_o
);

   logic [CNT_W-1:0] pcnt_q;
   logic             wrap;

   assign wrap   = (pcnt_q == div_i);
   assign tick_o = run_i && wrap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pcnt_q <= '0;
      else if (!run_i || wrap)
         pcnt_q <= '0;
      else
         pcnt_q <= pcnt_q + CNT_W'(1);
   end

   // R8: a fresh start always begins from a cleared prescale count
   assert_fresh_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_i) |-> (pcnt_q == '0));

   // R2: the count never runs past the divider setting
   assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> (pcnt_q <= div_i));

endmodule

// File: rtl/scl_div_phase_ctrl.sv
module scl_div_phase_ctrl
   import scl_div_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] prescale_i,
   input  logic [CNT_W-1:0] low_cnt_i,
   input  logic [CNT_W-1:0] high_cnt_i,
   input  logic [OVH_W-1:0] ovh_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] div_o,
   output logic             run_o,
   output logic             scl_o
);

   localparam int unsigned LEN_W = CNT_W + 1;

   scl_phase_e       state_q;
   logic [CNT_W-1:0] div_q;
   logic [LEN_W-1:0] low_len_q, high_len_q, ph_q;
   logic [LEN_W-1:0] low_len_d, high_len_d;
   logic             low_done, period_end, load;

   // Phase lengths including the overhead, formed at sampling time
   assign low_len_d  = {1'b0, low_cnt_i}  + LEN_W'(ovh_i);
   assign high_len_d = {1'b0, high_cnt_i} + LEN_W'(ovh_i);

   assign low_done   = (state_q == PH_LOW)  && tick_i && (ph_q == low_len_q  - LEN_W'(1));
   assign period_end = (state_q == PH_HIGH) && tick_i && (ph_q == high_len_q - LEN_W'(1));
   assign load       = (state_q == PH_IDLE) || period_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= PH_IDLE;
         div_q      <= '0;
         low_len_q  <= '0;
         high_len_q <= '0;
         ph_q       <= '0;
      end else if (!enable_i) begin
         state_q    <= PH_IDLE;
         div_q      <= '0;
         low_len_q  <= '0;
         high_len_q <= '0;
         ph_q       <= '0;
      end else if (load) begin
         div_q      <= prescale_i;
         low_len_q  <= low_len_d;
         high_len_q <= high_len_d;
         ph_q       <= '0;
         state_q    <= (high_cnt_i != '0) ? PH_LOW : PH_IDLE;
      end else if (low_done) begin
         state_q    <= PH_HIGH;
         ph_q       <= '0;
      end else if (tick_i) begin
         ph_q       <= ph_q + LEN_W'(1);
      end
   end

   assign div_o = div_q;
   assign run_o = (state_q != PH_IDLE);
   assign scl_o = (state_q != PH_LOW);

   // R1: disabling forces the idle, released state
   assert_disable_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (state_q == PH_IDLE));

   // R6: a zero high count keeps the divider parked
   assert_zero_high_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PH_IDLE && high_cnt_i == '0) |=> (state_q == PH_IDLE));

   // R7: sampled settings hold for the whole period
   assert_shadow_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && state_q != PH_IDLE && !period_end) |=>
         ($stable(div_q) && $stable(low_len_q) && $stable(high_len_q)));

   // R3: low phase count stays inside its length
   assert_low_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PH_LOW) |-> (ph_q < low_len_q));

   // R4: high phase count stays inside its length
   assert_high_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PH_HIGH) |-> (ph_q < high_len_q));

endmodule

// File: rtl/scl_clock_divider.sv
module scl_clock_divider
   import scl_div_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned FIXED_OVH = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] prescale_i,
   input  logic [CNT_W-1:0] low_cnt_i,
   input  logic [CNT_W-1:0] high_cnt_i,
   output logic             scl_o,
   output logic             mod_tick_o
);

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
         $error("scl_clock_divider: CNT_W must be 4..32");
      end
   endgenerate

   logic [OVH_W-1:0] ovh;
   logic [CNT_W-1:0] div;
   logic             run;
   logic             tick;

   scl_div_overhead #(
      .CNT_W     (CNT_W),
      .FIXED_OVH (FIXED_OVH)
   ) u_ovh (
      .prescale_i (prescale_i),
      .ovh_o      (ovh)
   );

   scl_div_prescaler #(
      .CNT_W (CNT_W)
   ) u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .div_i  (div),
      .tick_o (tick)
   );

   scl_div_phase_ctrl #(
      .CNT_W (CNT_W)
   ) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .enable_i   (enable_i),
      .prescale_i (prescale_i),
      .low_cnt_i  (low_cnt_i),
      .high_cnt_i (high_cnt_i),
      .ovh_i      (ovh),
      .tick_i     (tick),
      .div_o      (div),
      .run_o      (run),
      .scl_o      (scl_o)
   );

   assign mod_tick_o = tick;

   generate
      if (FIXED_OVH == 0) begin : g_ovh_chk
         // R5: overhead follows the prescale class
         assert_ovh_class_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            enable_i |-> ((prescale_i == '0)        ? (ovh == 3'd7) :
                          (prescale_i == CNT_W'(1)) ? (ovh == 3'd6) : (ovh == 3'd5)));
      end
   endgenerate

   // R1: a released line never ticks the module clock
   assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (scl_o && !mod_tick_o));

endmodule

// File: tb/scl_clock_divider_tb_top.sv
module scl_clock_divider_tb_top;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic [CNT_W-1:0] presc = '0;
   logic [CNT_W-1:0] lowc = '0;
   logic [CNT_W-1:0] highc = '0;
   logic             scl;
   logic             tick;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // Scoreboard of expected runs: level and length in cycles
   int exp_lvl[$];
   int exp_len[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   scl_clock_divider #(.CNT_W(CNT_W)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .enable_i   (enable),
      .prescale_i (presc),
      .low_cnt_i  (lowc),
      .high_cnt_i (highc),
      .scl_o      (scl),
      .mod_tick_o (tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic int dval(input int p);
      return (p == 0) ? 7 : (p == 1) ? 6 : 5;   // R5 overhead table
   endfunction

   function automatic int period(input int p, input int l, input int h);
      return (p + 1) * (l + h + 2 * dval(p));
   endfunction

   task automatic push_periods(input int p, input int l, input int h, input int n);
      for (int i = 0; i < n; i++) begin
         exp_lvl.push_back(0); exp_len.push_back((p + 1) * (l + dval(p)));
         exp_lvl.push_back(1); exp_len.push_back((p + 1) * (h + dval(p)));
      end
   endtask

   task automatic drive(input bit en, input int p, input int l, input int h);
      enable = en; presc = CNT_W'(p); lowc = CNT_W'(l); highc = CNT_W'(h);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(posedge clk);
      #1;
   endtask

   // R2: spacing between consecutive module ticks
   task automatic tick_gap(input int p);
      int gap = 0;
      for (int i = 0; i < 64 && !tick; i++) @(negedge clk);
      @(negedge clk); gap = 1;
      for (int i = 0; i < 64 && !tick; i++) begin @(negedge clk); gap++; end
      check(gap == p + 1, "R2 tick spacing", gap, p + 1);
   endtask

   // Full-period session: P periods, then disable just after the next fall
   task automatic session(input int p, input int l, input int h, input int n, input bit gap_chk);
      int s;
      @(posedge clk); #1;
      s = cyc;
      drive(1'b1, p, l, h);
      push_periods(p, l, h, n);
      if (gap_chk) tick_gap(p);
      wait_until(s + n * period(p, l, h) + 2);
      enable = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   // Monitor: measures each complete run of scl inside an enabled window
   int  run_len = 0;
   int  run_lvl = 1;
   bit  run_ok  = 1'b0;
   always @(negedge clk) begin
      if (!rst_n || !enable) begin
         run_ok  = 1'b0;
         run_lvl = 1;
         run_len = 0;
      end else if (int'(scl) != run_lvl) begin
         if (run_ok) begin
            if (exp_lvl.size() == 0) begin
               check(1'b0, (run_lvl == 0) ? "R3 unexpected low run" : "R4 unexpected high run",
                     run_len, 0);
            end else begin
               int el, ln;
               el = exp_lvl.pop_front();
               ln = exp_len.pop_front();
               check(el == run_lvl, "R3 R4 run level", run_lvl, el);
               check(ln == run_len, (run_lvl == 0) ? "R3 R5 low run length" : "R4 R5 high run length",
                     run_len, ln);
            end
         end
         run_ok  = 1'b1;
         run_lvl = int'(scl);
         run_len = 1;
      end else begin
         run_len++;
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int s;
      int bad;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(scl == 1'b1, "R1 scl in reset", scl, 1);
      check(tick == 1'b0, "R1 tick in reset", tick, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      drive(1'b0, 2, 3, 4);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!scl || tick) bad++;
      end
      check(bad == 0, "R1 disabled stays released", bad, 0);

      // R3 R4 R5 R2: prescale classes 0, 1, >=2; low count 0 included
      session(0, 2, 3, 3, 1'b1);
      session(1, 4, 1, 2, 1'b1);
      session(3, 0, 2, 2, 1'b1);
      session(2, 10, 4, 1, 1'b0);

      // R7: settings changed inside the first low phase apply from period two
      @(posedge clk); #1;
      s = cyc;
      drive(1'b1, 0, 2, 3);
      push_periods(0, 2, 3, 1);
      push_periods(1, 1, 1, 2);
      wait_until(s + 3);
      drive(1'b1, 1, 1, 1);
      wait_until(s + period(0, 2, 3) + 2 * period(1, 1, 1) + 2);
      enable = 1'b0;
      repeat (3) @(posedge clk);

      // R6: zero high count never starts the clock
      @(posedge clk); #1;
      drive(1'b1, 0, 3, 0);
      bad = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (!scl || tick) bad++;
      end
      check(bad == 0, "R6 zero high count holds line", bad, 0);
      @(posedge clk); #1;
      enable = 1'b0;
      repeat (3) @(posedge clk);

      // R7 R6: high count cleared mid-period stops the clock after that period
      @(posedge clk); #1;
      s = cyc;
      drive(1'b1, 0, 2, 3);
      exp_lvl.push_back(0); exp_len.push_back(9);
      wait_until(s + 3);
      highc = '0;
      wait_until(s + period(0, 2, 3) + 30);
      @(negedge clk);
      check(scl == 1'b1, "R7 R6 stopped after period scl", scl, 1);
      check(tick == 1'b0, "R7 R6 stopped after period tick", tick, 0);
      @(posedge clk); #1;
      enable = 1'b0;
      repeat (3) @(posedge clk);

      // R8: disable partway through a low phase, then restart fresh
      @(posedge clk); #1;
      s = cyc;
      drive(1'b1, 0, 20, 3);
      wait_until(s + 10);
      check(scl == 1'b0, "R8 line low before disable", scl, 0);
      enable = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(scl == 1'b1, "R8 released after disable", scl, 1);
      check(tick == 1'b0, "R8 ticks stop after disable", tick, 0);
      session(0, 2, 3, 1, 1'b0);

      repeat (5) @(posedge clk);
      check(exp_lvl.size() == 0, "R3 R4 scoreboard drained", exp_lvl.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule